// File: doc/BRIEF.md
# Write-Only Two-Wire Clock Enable Controller

This block is a slave on a two-wire SMBus-style serial bus that accepts write transfers only. It samples the bus clock and data lines with a fast system clock. It finds the bus start and stop conditions, gathers bytes most significant bit first, and answers each accepted byte by pulling the data line low through an open-drain output enable. After a matching address byte it expects a command byte, which it ignores, and then a byte-count byte. The data bytes after those two fill three enable registers, always in the same order and always starting at the first register, because the block has no sub-address.

The ten register bits that are in use each control one buffered clock output. A set bit lets that clock through. A cleared bit forces the output low. The enable seen by each gate is held in a latch that is open only while the source clock is low, so a change of enable never cuts a pulse short. Register contents stay in place between transfers. A new transfer changes only the registers that its data bytes reach.

Top module: `smb_clkgate_ctrl`

## Requirements
- R1: A falling data line while the bus clock is high is a START and restarts address reception, also in the middle of a transfer. A rising data line while the bus clock is high is a STOP, which releases the data line and ends the transfer.
- R2: For each accepted byte, `sda_oe` goes high after the falling bus clock edge that follows the eighth data bit. It returns low after the falling edge of the ninth bus clock. `sda_oe` only changes while the synchronized bus clock is low.
- R3: Only the address byte 0xD2 is acknowledged. This is device address 0x69 with the read/write bit 0 in the least significant position. Any other address, and any read request such as 0xD3, gets no acknowledge, and no later byte of that transfer is acknowledged or written.
- R4: The first and second bytes after the address are the command byte and the count byte. Both are acknowledged, and neither changes any register.
- R5: The third, fourth and fifth bytes after the address are written to register 0, register 1 and register 2, in that order. Later bytes within the limit are acknowledged and discarded.
- R6: At most 10 bytes after the address are acknowledged. The eleventh byte and every byte after it in the same transfer get no acknowledge.
- R7: After reset, register 0 is 0xFF, register 1 is 0xFF and register 2 is 0xC3, so all ten outputs run.
- R8: Outputs 3..0 are enabled by register 0 bits 3..0. Outputs 5..4 are enabled by register 2 bits 7..6. Outputs 9..6 are enabled by register 1 bits 7..4. All other bits have no effect.
- R9: An output with enable 1 follows its source clock, and an output with enable 0 stays low. A new enable value takes effect only after the source clock has been low, so an output that is high stays high until its source falls.
- R10: Registers keep their values across transfers. A transfer changes only the registers that its data bytes reach.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, pull the data line low (acknowledge) |
| clk_src | input | 10 | Buffered source clocks |
| clk_out | output | 10 | Gated clock outputs |

## Verification
Register writes are tried with a full three-register block, with a short write that reaches only register 0, and with an overlong write that crosses the byte limit. Comparing these shows that the register order is fixed, that unwritten registers keep their values, and where acknowledges stop. A foreign address, a read request and a START in the middle of a transfer separate address matching from plain byte counting. Changing an enable while the source clock is high shows that the gate waits for the low phase.

// File: rtl/smbcg_pkg.sv
package smbcg_pkg;
   typedef enum logic [1:0] {
      PH_IDLE,
      PH_RECV,
      PH_ACK,
      PH_SKIP
   } phase_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/smbcg_sync.sv
module smbcg_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin : p_param_chk
      if (STAGES < 2) $fatal(1, "smbcg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '1;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/smbcg_link.sv
module smbcg_link
   import smbcg_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR  = 7'h69,
   parameter int unsigned MAX_BYTES = 10,
   parameter int unsigned NUM_REGS  = 3,
   parameter int unsigned SEL_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [SEL_W-1:0]  wr_sel,
   output logic [BYTE_W-1:0] wr_data
);
   localparam int unsigned   HDR_BYTES = 3;
   localparam int unsigned   IDX_W     = $clog2(MAX_BYTES + 2);
   localparam logic [IDX_W-1:0] LIMIT_IDX = IDX_W'(MAX_BYTES);
   localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(HDR_BYTES);
   localparam logic [IDX_W-1:0] END_IDX   = IDX_W'(HDR_BYTES + NUM_REGS);
   localparam logic [BYTE_W-1:0] WR_ADDR  = {DEV_ADDR, 1'b0};

   initial begin : p_param_chk
      if (MAX_BYTES + 1 < HDR_BYTES + NUM_REGS)
         $fatal(1, "smbcg_link: byte limit too small for register count");
      if ((1 << SEL_W) < NUM_REGS)
         $fatal(1, "smbcg_link: SEL_W too narrow");
   end

   phase_e            phase;
   logic              scl_p, sda_p;
   logic [BYTE_W-1:0] shreg;
   logic [3:0]        bit_cnt;
   logic [IDX_W-1:0]  byte_idx;

   logic start_evt, stop_evt, scl_rise, scl_fall, accept, byte_done;

   assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign byte_done = scl_fall && (bit_cnt == 4'd8);
   assign accept    = (byte_idx == '0) ? (shreg == WR_ADDR) : (byte_idx <= LIMIT_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p    <= 1'b1;
         sda_p    <= 1'b1;
         phase    <= PH_IDLE;
         shreg    <= '0;
         bit_cnt  <= '0;
         byte_idx <= '0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_sel   <= '0;
         wr_data  <= '0;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
         wr_en <= 1'b0;
         if (start_evt) begin
            phase    <= PH_RECV;
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
         end else if (stop_evt) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (phase)
               PH_RECV: begin
                  if (scl_rise && bit_cnt < 4'd8) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (byte_done) begin
                     if (accept) begin
                        sda_oe <= 1'b1;
                        phase  <= PH_ACK;
                        if (byte_idx >= DATA_IDX && byte_idx < END_IDX) begin
                           wr_en   <= 1'b1;
                           wr_sel  <= SEL_W'(byte_idx - DATA_IDX);
                           wr_data <= shreg;
                        end
                     end else begin
                        phase <= PH_SKIP;
                     end
                  end
               end
               PH_ACK: begin
                  if (scl_fall) begin
                     sda_oe   <= 1'b0;
                     bit_cnt  <= '0;
                     byte_idx <= byte_idx + 1'b1;
                     phase    <= PH_RECV;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/smbcg_regs.sv
module smbcg_regs
   import smbcg_pkg::*;
#(
   parameter int unsigned               NUM_REGS = 3,
   parameter int unsigned               SEL_W    = 2,
   parameter logic [NUM_REGS*BYTE_W-1:0] RST_VALS = 24'hC3FFFF
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [SEL_W-1:0]             wr_sel,
   input  logic [BYTE_W-1:0]            wr_data,
   output logic [NUM_REGS*BYTE_W-1:0]   reg_flat
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reg_flat[g*BYTE_W +: BYTE_W] <= RST_VALS[g*BYTE_W +: BYTE_W];
         else if (wr_en && wr_sel == SEL_W'(g))
            reg_flat[g*BYTE_W +: BYTE_W] <= wr_data;
      end
   end
endmodule

// File: rtl/smbcg_gate.sv
module smbcg_gate (
   input  logic src,
   input  logic en,
   output logic out
);
   logic en_q;

   always_latch begin
      if (!src) en_q = en;
   end

   assign out = src & en_q;
endmodule

// File: rtl/smb_clkgate_ctrl.sv
module smb_clkgate_ctrl
   import smbcg_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h69,
   parameter int unsigned MAX_BYTES   = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       sda_oe,
   input  logic [9:0] clk_src,
   output logic [9:0] clk_out
);
   localparam int unsigned NUM_REGS = 3;
   localparam int unsigned SEL_W    = $clog2(NUM_REGS);
   localparam int unsigned NUM_OUT  = 10;

   logic                        scl_s, sda_s;
   logic                        wr_en;
   logic [SEL_W-1:0]            wr_sel;
   logic [BYTE_W-1:0]           wr_data;
   logic [NUM_REGS*BYTE_W-1:0]  reg_flat;
   logic [NUM_OUT-1:0]          en_vec;

   smbcg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     ({scl_s, sda_s})
   );

   smbcg_link #(
      .DEV_ADDR  (DEV_ADDR),
      .MAX_BYTES (MAX_BYTES),
      .NUM_REGS  (NUM_REGS),
      .SEL_W     (SEL_W)
   ) u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_s   (scl_s),
      .sda_s   (sda_s),
      .sda_oe  (sda_oe),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data)
   );

   smbcg_regs #(
      .NUM_REGS (NUM_REGS),
      .SEL_W    (SEL_W),
      .RST_VALS (24'hC3FFFF)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .reg_flat (reg_flat)
   );

   // enable routing: reg1[7:4] -> 9..6, reg2[7:6] -> 5..4, reg0[3:0] -> 3..0
   assign en_vec = {reg_flat[15:12], reg_flat[23:22], reg_flat[3:0]};

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
      smbcg_gate u_gate (
         .src (clk_src[g]),
         .en  (en_vec[g]),
         .out (clk_out[g])
      );
   end
endmodule

// File: rtl/smbcg_chk.sv
module smbcg_chk #(
   parameter int unsigned NUM_REGS = 3,
   parameter int unsigned SEL_W    = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_s,
   input logic                  sda_s,
   input logic                  sda_oe,
   input logic                  wr_en,
   input logic [SEL_W-1:0]      wr_sel,
   input logic [NUM_REGS*8-1:0] reg_flat
);
   AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_s); // R2

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(sda_s) && sda_s) |=> !sda_oe); // R1

   AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> sda_oe); // R5

   AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_sel < SEL_W'(NUM_REGS))); // R5

   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(reg_flat)); // R10
endmodule

bind smb_clkgate_ctrl smbcg_chk #(.NUM_REGS(3), .SEL_W(2)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .sda_s    (sda_s),
   .sda_oe   (sda_oe),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .reg_flat (reg_flat)
);

// File: tb/sim_smb_clkgate_ctrl.sv
module sim_smb_clkgate_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;

   typedef struct {
      string      tag;
      logic [9:0] val;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic       sda_bus;
   logic [9:0] clk_src = '0;
   logic [9:0] clk_out;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;

   item_t      exp_q[$];
   logic [9:0] act_q[$];

   logic [7:0] m_r0 = 8'hFF, m_r1 = 8'hFF, m_r2 = 8'hC3;

   assign sda_bus = sda_m & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_clkgate_ctrl u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_in  (scl_m),
      .sda_in  (sda_bus),
      .sda_oe  (sda_oe),
      .clk_src (clk_src),
      .clk_out (clk_out)
   );

   function automatic logic [9:0] exp_out();
      return {m_r1[7:4], m_r2[7:6], m_r0[3:0]};
   endfunction

   // monitor: compare results against expectations in order
   always @(negedge clk) begin
      while (exp_q.size() > 0 && act_q.size() > 0) begin
         item_t      e;
         logic [9:0] a;
         e = exp_q.pop_front();
         a = act_q.pop_front();
         n_tests++;
         if (a !== e.val) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", e.tag, a, e.val);
         end
      end
   end

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      @(negedge clk) sda_m = 1'b1;
      wait_q();
      scl_m = 1'b1;
      wait_q();
      sda_m = 1'b0;
      wait_q();
      scl_m = 1'b0;
      wait_q();
   endtask

   task automatic bus_stop();
      @(negedge clk) sda_m = 1'b0;
      wait_q();
      scl_m = 1'b1;
      wait_q();
      sda_m = 1'b1;
      wait_q();
   endtask

   task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
      logic ack;
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk) sda_m = b[i];
         wait_q();
         scl_m = 1'b1;
         wait_q();
         wait_q();
         scl_m = 1'b0;
         wait_q();
      end
      @(negedge clk) sda_m = 1'b1;
      wait_q();
      scl_m = 1'b1;
      wait_q();
      ack = ~sda_bus;
      wait_q();
      scl_m = 1'b0;
      wait_q();
      exp_q.push_back('{tag, 10'(exp_ack)});
      act_q.push_back(10'(ack));
   endtask

   task automatic check_outs(input string tag);
      @(negedge clk) clk_src = '0;
      repeat (3) @(negedge clk);
      exp_q.push_back('{{tag, " low phase"}, 10'h000});
      act_q.push_back(clk_out);
      clk_src = '1;
      repeat (3) @(negedge clk);
      exp_q.push_back('{tag, exp_out()});
      act_q.push_back(clk_out);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      check_outs("R7 reset values");

      // full write of the three registers
      bus_start();
      send_byte(8'hD2, 1'b1, "R3 write address ack");
      send_byte(8'h5A, 1'b1, "R4 command ack");
      send_byte(8'h03, 1'b1, "R4 count ack");
      send_byte(8'hF5, 1'b1, "R5 reg0 ack");
      send_byte(8'h3F, 1'b1, "R5 reg1 ack");
      send_byte(8'h40, 1'b1, "R5 reg2 ack");
      bus_stop();
      m_r0 = 8'hF5; m_r1 = 8'h3F; m_r2 = 8'h40;
      check_outs("R8 mapping after full write");

      // foreign address
      bus_start();
      send_byte(8'hA0, 1'b0, "R3 foreign address nack");
      send_byte(8'h00, 1'b0, "R3 ignored byte");
      send_byte(8'h01, 1'b0, "R3 ignored byte");
      send_byte(8'h00, 1'b0, "R3 ignored byte");
      bus_stop();
      check_outs("R3 regs unchanged after foreign address");

      // read request
      bus_start();
      send_byte(8'hD3, 1'b0, "R3 read request nack");
      send_byte(8'h00, 1'b0, "R3 ignored after read");
      bus_stop();
      check_outs("R3 regs unchanged after read");

      // short write reaches only register 0
      bus_start();
      send_byte(8'hD2, 1'b1, "R10 address ack");
      send_byte(8'h00, 1'b1, "R4 command ack");
      send_byte(8'h01, 1'b1, "R4 count ack");
      send_byte(8'hFF, 1'b1, "R10 reg0 ack");
      bus_stop();
      m_r0 = 8'hFF;
      check_outs("R10 only reg0 changed");

      // START in the middle of a transfer
      bus_start();
      send_byte(8'hD2, 1'b1, "R1 address ack");
      send_byte(8'h77, 1'b1, "R1 command ack");
      bus_start();
      send_byte(8'hD2, 1'b1, "R1 address after restart");
      send_byte(8'h00, 1'b1, "R1 command after restart");
      send_byte(8'h01, 1'b1, "R1 count after restart");
      send_byte(8'hF0, 1'b1, "R1 reg0 after restart");
      bus_stop();
      m_r0 = 8'hF0;
      check_outs("R1 restart realigns to reg0");

      // overlong write crosses the byte limit
      bus_start();
      send_byte(8'hD2, 1'b1, "R6 address ack");
      send_byte(8'h00, 1'b1, "R6 command ack");
      send_byte(8'h08, 1'b1, "R6 count ack");
      send_byte(8'h0F, 1'b1, "R6 reg0 ack");
      send_byte(8'hF0, 1'b1, "R6 reg1 ack");
      send_byte(8'hC0, 1'b1, "R6 reg2 ack");
      for (int k = 6; k <= 10; k++)
         send_byte(8'h00, 1'b1, "R5 extra byte within limit ack");
      send_byte(8'h00, 1'b0, "R6 eleventh byte nack");
      send_byte(8'h00, 1'b0, "R6 twelfth byte nack");
      bus_stop();
      m_r0 = 8'h0F; m_r1 = 8'hF0; m_r2 = 8'hC0;
      check_outs("R5 extras discarded");

      // enable cleared while sources are high
      bus_start();
      send_byte(8'hD2, 1'b1, "R9 address ack");
      send_byte(8'h00, 1'b1, "R9 command ack");
      send_byte(8'h01, 1'b1, "R9 count ack");
      send_byte(8'h00, 1'b1, "R9 reg0 ack");
      bus_stop();
      repeat (4) @(negedge clk);
      exp_q.push_back('{"R9 output held high until source falls", exp_out()});
      act_q.push_back(clk_out);
      m_r0 = 8'h00;
      check_outs("R9 disabled outputs low");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule